// File: doc/BRIEF.md
# Programming frame clock-count guard

This block sits beside the serial command front end of a small serial-access nonvolatile memory. It watches the chip-select level and the rising edges of the serial clock, already brought into the system clock domain as a level and a one-cycle pulse. From the first `1` sampled while select is high, which is the start bit, it counts clock edges. When select drops, it compares that count with the exact frame length that the decoded command needs under the current word organization.

The result is a registered go or abort qualifier, together with the decoded command kind. The programming sequencer must see go before it starts a self-timed cycle. An abort means that a clock glitch added or removed an edge, which would shift the address and data bits. In that case the command must be dropped and the array left untouched. Read frames are never judged, because their length is open-ended.

Top module: `fcg_frame_guard`

## Requirements
- R1: After reset, `go_o` and `abort_o` are 0 and `kind_o` is 0.
- R2: While select is high and no start bit has been seen, edges sampled with `sdi_i` = 0 are not counted. The first edge with `sdi_i` = 1 is the start bit and counts as edge 1.
- R3: With `org16_i` = 0, a frame whose opcode is write (bits 2..3 after the start bit = `01`) or write-all (`00` followed by `01`) gives go only at exactly 18 edges. Any other count gives abort.
- R4: With `org16_i` = 1, write and write-all frames give go only at exactly 25 edges. Any other count gives abort.
- R5: Erase (`11`), erase-all (`00` then `10`), write-enable (`00` then `11`) and write-disable (`00` then `00`) frames give go only at exactly 10 edges with `org16_i` = 0 and 9 edges with `org16_i` = 1. Any other count gives abort.
- R6: A read frame (`10`) never raises go or abort, whatever its length.
- R7: The edge count saturates at 31, so a frame of 31 or more edges always aborts, even where a wrapping counter would land on a valid length.
- R8: The flags are set in the first cycle after the cycle in which select is first sampled low. They hold while select stays low and are cleared in the first cycle after select is sampled high again. go and abort are never both 1.
- R9: `kind_o` reports the decoded command with the flags: 1 read, 2 write, 3 erase, 4 write-enable, 5 write-disable, 6 erase-all, 7 write-all, and 0 when the command is undecided.
- R10: A started frame that ends before its opcode is decided (fewer than 3 edges, or opcode `00` with fewer than 5 edges) gives abort with `kind_o` = 0. A frame with no start bit gives neither flag.
- R11: Edge pulses while select is low, including one in the very cycle select is first seen low, are not counted and do not change the held result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip-select level, synchronized |
| sck_rise_i | input | 1 | One-cycle pulse per rising serial clock edge |
| sdi_i | input | 1 | Serial data bit sampled at that edge |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| go_o | output | 1 | Frame length matched; programming may start |
| abort_o | output | 1 | Frame length wrong or command undecided |
| kind_o | output | 3 | Decoded command kind (R9 encoding) |

## Verification
Two events share a cycle at the end of every frame. Select is first seen low, and a clock-edge pulse arrives in that same cycle. The bench drives both together in every frame, and the verdict must reflect only the edges counted while select was high. After the verdict, more edge pulses are sent while select stays low. Select is then raised, and the bench checks that the held result is not disturbed and is cleared one cycle after the rise. The length sweep covers every command in both organizations from 1 to 34 edges and at 50 edges, so the verdict is judged on both sides of each exact length and beyond saturation.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_READ  = 3'd1,
    FK_WRITE = 3'd2,
    FK_ERASE = 3'd3,
    FK_WREN  = 3'd4,
    FK_WRDIS = 3'd5,
    FK_ERALL = 3'd6,
    FK_WRALL = 3'd7
  } frame_kind_e;
endpackage

// File: rtl/fcg_edge_counter.sv
module fcg_edge_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic             din,
  output logic             started,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      started <= 1'b0;
      count   <= '0;
    end else if (tick) begin
      if (!started) begin
        if (din) begin
          started <= 1'b1;
          count   <= CNT_W'(1);
        end
      end else if (count != SAT) begin
        count <= count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fcg_op_capture.sv
module fcg_op_capture import fcg_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic             din,
  input  logic             started,
  input  logic [CNT_W-1:0] count,
  output logic [OPC_W-1:0] code
);
  // bit b is the (OPC_W-b)th bit after the start bit
  for (genvar b = 0; b < OPC_W; b++) begin : g_bit
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(OPC_W - b);
    always_ff @(posedge clk) begin
      if (rst || !active) begin
        code[b] <= 1'b0;
      end else if (tick && started && count == SLOT) begin
        code[b] <= din;
      end
    end
  end
endmodule

// File: rtl/fcg_decoder.sv
module fcg_decoder import fcg_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] count,
  input  logic [OPC_W-1:0] code,
  output frame_kind_e      kind,
  output logic             resolved,
  output logic             checked
);
  localparam logic [CNT_W-1:0] MAIN_DONE = CNT_W'(3);
  localparam logic [CNT_W-1:0] EXT_DONE  = CNT_W'(5);

  always_comb begin
    kind     = FK_NONE;
    resolved = 1'b0;
    checked  = 1'b1;
    if (count >= MAIN_DONE) begin
      unique case (code[3:2])
        2'b10: begin kind = FK_READ;  resolved = 1'b1; checked = 1'b0; end
        2'b01: begin kind = FK_WRITE; resolved = 1'b1; end
        2'b11: begin kind = FK_ERASE; resolved = 1'b1; end
        default: begin
          if (count >= EXT_DONE) begin
            resolved = 1'b1;
            unique case (code[1:0])
              2'b11:   kind = FK_WREN;
              2'b00:   kind = FK_WRDIS;
              2'b10:   kind = FK_ERALL;
              default: kind = FK_WRALL;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fcg_len_table.sv
module fcg_len_table import fcg_pkg::*; #(
  parameter int CNT_W    = 5,
  parameter int OP_W     = 2,
  parameter int ADDR_X8  = 7,
  parameter int ADDR_X16 = 6,
  parameter int DATA_X8  = 8,
  parameter int DATA_X16 = 16
) (
  input  frame_kind_e      kind,
  input  logic             org16,
  output logic [CNT_W-1:0] exp_len
);
  localparam int CMD_X8   = 1 + OP_W + ADDR_X8;
  localparam int CMD_X16  = 1 + OP_W + ADDR_X16;
  localparam int DATA_L8  = CMD_X8 + DATA_X8;
  localparam int DATA_L16 = CMD_X16 + DATA_X16;

  logic carries_data;
  assign carries_data = (kind == FK_WRITE) || (kind == FK_WRALL);

  always_comb begin
    unique case ({org16, carries_data})
      2'b00:   exp_len = CNT_W'(CMD_X8);
      2'b01:   exp_len = CNT_W'(DATA_L8);
      2'b10:   exp_len = CNT_W'(CMD_X16);
      default: exp_len = CNT_W'(DATA_L16);
    endcase
  end
endmodule

// File: rtl/fcg_frame_guard.sv
module fcg_frame_guard import fcg_pkg::*; #(
  parameter int CNT_W    = 5,
  parameter int OP_W     = 2,
  parameter int ADDR_X8  = 7,
  parameter int ADDR_X16 = 6,
  parameter int DATA_X8  = 8,
  parameter int DATA_X16 = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_i,
  input  logic       sck_rise_i,
  input  logic       sdi_i,
  input  logic       org16_i,
  output logic       go_o,
  output logic       abort_o,
  output logic [2:0] kind_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic             cs_q;
  logic             started;
  logic [CNT_W-1:0] edge_cnt;
  logic [OPC_W-1:0] op_code;
  frame_kind_e      kind_dec;
  logic             resolved, checked;
  logic [CNT_W-1:0] exp_len;
  logic             cs_fall, cs_rise;
  logic             go_d, abort_d;

  fcg_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .active(cs_i), .tick(sck_rise_i), .din(sdi_i),
    .started(started), .count(edge_cnt)
  );

  fcg_op_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .active(cs_i), .tick(sck_rise_i), .din(sdi_i),
    .started(started), .count(edge_cnt), .code(op_code)
  );

  fcg_decoder #(.CNT_W(CNT_W)) u_dec (
    .count(edge_cnt), .code(op_code), .kind(kind_dec),
    .resolved(resolved), .checked(checked)
  );

  fcg_len_table #(
    .CNT_W(CNT_W), .OP_W(OP_W), .ADDR_X8(ADDR_X8), .ADDR_X16(ADDR_X16),
    .DATA_X8(DATA_X8), .DATA_X16(DATA_X16)
  ) u_len (
    .kind(kind_dec), .org16(org16_i), .exp_len(exp_len)
  );

  assign cs_fall = cs_q && !cs_i;
  assign cs_rise = !cs_q && cs_i;

  assign go_d    = started && resolved && checked
                   && (edge_cnt == exp_len) && (edge_cnt != SAT);
  assign abort_d = started && (!resolved || (checked && !go_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_rise) begin
      go_o    <= 1'b0;
      abort_o <= 1'b0;
      kind_o  <= FK_NONE;
    end else if (cs_fall) begin
      go_o    <= go_d;
      abort_o <= abort_d;
      kind_o  <= started ? kind_dec : FK_NONE;
    end
  end
endmodule

// File: rtl/fcg_frame_guard_chk.sv
module fcg_frame_guard_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_i,
  input logic             go_o,
  input logic             abort_o,
  input logic [2:0]       kind_o,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT = '1;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(go_o && abort_o)); // R8

  AST_CLEAR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_i) |=> (!go_o && !abort_o && kind_o == 3'd0)); // R8

  AST_QUIET_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_i && $past(cs_i)) |-> (!go_o && !abort_o)); // R8

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cs_i && $past(!cs_i) && $past(!cs_i, 2))
      |-> ($stable(go_o) && $stable(abort_o) && $stable(kind_o))); // R11

  AST_READ_UNJUDGED: assert property (@(posedge clk) disable iff (rst)
    (kind_o == 3'd1) |-> (!go_o && !abort_o)); // R6

  AST_GO_NEEDS_KIND: assert property (@(posedge clk) disable iff (rst)
    go_o |-> (kind_o >= 3'd2)); // R9

  AST_SAT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (cs_i && $past(cs_i) && $past(cnt) == SAT) |-> (cnt == SAT)); // R7

  AST_COUNT_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cs_i |=> (cnt == '0)); // R11
endmodule

bind fcg_frame_guard fcg_frame_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_i(cs_i), .go_o(go_o), .abort_o(abort_o),
  .kind_o(kind_o), .cnt(edge_cnt)
);

// File: tb/tb_fcg_frame_guard.sv
`timescale 1ns/1ps
module tb_fcg_frame_guard;
  logic clk = 1'b0;
  logic rst, cs, sck, sdi, org16;
  logic go, abort;
  logic [2:0] kind;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fcg_frame_guard dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sck_rise_i(sck), .sdi_i(sdi),
    .org16_i(org16), .go_o(go), .abort_o(abort), .kind_o(kind)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL R8 watchdog expired: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input bit eg, input bit ea, input int ek);
    checks++;
    if (go !== eg || abort !== ea || kind !== 3'(ek)) begin
      failures++;
      $display("FAIL %s actual go=%0b abort=%0b kind=%0d expected go=%0b abort=%0b kind=%0d",
               tag, go, abort, kind, eg, ea, ek);
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk) sdi = b; sck = 1'b1;
    @(negedge clk) sck = 1'b0; sdi = 1'b0;
  endtask

  // independent model of the requirements
  task automatic expect_of(input bit org, input int n, input logic [3:0] code,
                           output bit eg, output bit ea, output int ek, output string tag);
    int explen, kc;
    eg = 0; ea = 0; ek = 0;
    if (n == 0) begin tag = "R10"; return; end
    if (n < 3) begin ea = 1; tag = "R10"; return; end
    if (code[3:2] == 2'b10) begin ek = 1; tag = "R6"; return; end
    if (code[3:2] == 2'b00 && n < 5) begin ea = 1; tag = "R10"; return; end
    case (code[3:2])
      2'b01: ek = 2;
      2'b11: ek = 3;
      default: case (code[1:0])
        2'b11: ek = 4;
        2'b00: ek = 5;
        2'b10: ek = 6;
        default: ek = 7;
      endcase
    endcase
    if (ek == 2 || ek == 7) begin
      explen = org ? 25 : 18;
      tag = org ? "R4" : "R3";
    end else begin
      explen = org ? 9 : 10;
      tag = "R5";
    end
    kc = (n > 31) ? 31 : n;
    if (n > 31) tag = "R7";
    eg = (kc == explen);
    ea = !eg;
  endtask

  task automatic run_frame(input bit org, input int lead, input int n,
                           input logic [3:0] code, input int extra_low, input string note);
    bit eg, ea; int ek; string tag;
    expect_of(org, n, code, eg, ea, ek, tag);
    org16 = org;
    @(negedge clk) cs = 1'b1; sck = 1'b0; sdi = 1'b0;
    @(negedge clk) check({"R8 clear after rise ", note}, 0, 0, 0);
    for (int i = 0; i < lead; i++) send(1'b0);          // R2 leading zeros
    for (int i = 1; i <= n; i++) begin
      if (i == 1)      send(1'b1);
      else if (i <= 5) send(code[5-i]);
      else             send((i % 3) == 0);
    end
    // R11: edge pulse in the very cycle select is first seen low
    @(negedge clk) cs = 1'b0; sck = 1'b1; sdi = 1'b1;
    @(negedge clk) sck = 1'b0; sdi = 1'b0;
    check({tag, " R9 verdict ", note}, eg, ea, ek);
    for (int i = 0; i < extra_low; i++) send(1'b1);
    @(negedge clk) check({"R8 R11 hold ", note}, eg, ea, ek);
  endtask

  function automatic logic [3:0] code_of(input int k);
    case (k)
      0: return 4'b1011;  // read
      1: return 4'b0110;  // write
      2: return 4'b1101;  // erase
      3: return 4'b0011;  // write-enable
      4: return 4'b0000;  // write-disable
      5: return 4'b0010;  // erase-all
      default: return 4'b0001; // write-all
    endcase
  endfunction

  initial begin
    rst = 1'b1; cs = 1'b0; sck = 1'b0; sdi = 1'b0; org16 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk) check("R1 after release", 0, 0, 0);

    run_frame(0, 6, 18, 4'b0110, 0, "R2 long preamble write x8");
    run_frame(1, 0, 9, 4'b0011, 3, "R11 edges while low");
    run_frame(0, 4, 0, 4'b0000, 0, "R10 no start bit");

    for (int org = 0; org < 2; org++)
      for (int k = 0; k < 7; k++) begin
        for (int n = 1; n <= 34; n++)
          run_frame(org[0], n % 3, n, code_of(k), n % 2, "sweep");
        run_frame(org[0], 1, 50, code_of(k), 0, "R7 wrap length");
      end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule